// File: doc/BRIEF.md
# Handshaked Bus Memory Slave

This block is one memory module on a shared bus where one master at a time drives transfers. The master is either the processor or a DMA-capable peripheral controller. It places a full 18-bit byte address on the bus together with a read/write command and, for writes, the data. The upper address bits name the module and the lower bits name the word inside it. The slave takes part only when the module field matches its own identity parameter.

Completion is signalled through a four-phase request/acknowledge exchange rather than a fixed number of bus cycles, so a master works unchanged with modules of any speed:

1. The master raises the request once address and command are stable.
2. The slave raises acknowledge when the access is complete.
3. The master lowers the request.
4. The slave lowers acknowledge.

The request crosses into the slave's clock through a two-stage synchroniser. The internal access time is a parameter counted in clock cycles. Both 16-bit word transfers and 8-bit byte writes are supported.

Top module: `bus_mem_slave`

## Requirements
- R1: While reset is asserted and right after it, `ack` is low and `rdata` is zero.
- R2: A request whose `addr[17:13]` equals `MODULE_ID` makes `ack` rise on the (LATENCY+3)-th rising clock edge at which `req` is high, counting the first one as 1. This is two synchroniser stages plus one decode cycle plus LATENCY. `ack` never rises before LATENCY cycles of request have passed.
- R3: `ack` stays high for as long as `req` stays high. It falls on the third rising edge after `req` is first sampled low. It never rises while no request is pending.
- R4: A read (`wr`=0) returns in `rdata` the 16-bit word stored at word offset `addr[OFF_W:1]`. `rdata` holds that value without change for as long as `ack` is high.
- R5: A word write (`wr`=1, `byte_mode`=0) stores all 16 bits of `wdata` at the addressed word.
- R6: A byte write (`wr`=1, `byte_mode`=1) changes one byte of the word. If `addr[0]`=0, bits [7:0] take `wdata[7:0]`. If `addr[0]`=1, bits [15:8] take `wdata[15:8]`. The other byte of the word keeps its previous value.
- R7: A request whose `addr[17:13]` differs from `MODULE_ID` is never acknowledged and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request from the current master, asynchronous to `clk` |
| wr | input | 1 | 1 = write, 0 = read |
| byte_mode | input | 1 | 1 = 8-bit write to the lane chosen by `addr[0]` |
| addr | input | 18 | Byte address; [17:13] module select, [OFF_W:1] word offset |
| wdata | input | 16 | Write data |
| ack | output | 1 | Transfer complete |
| rdata | output | 16 | Read data, valid while `ack` is high |

## Verification
A wrong handshake state shows at once as `ack` rising one or more cycles early or late, or as `ack` staying high after the request is gone. The per-clock comparison against the reference model flags it on the first cycle it appears. A wrong latency count shifts the acknowledge edge by exactly the size of the error. Corrupted storage, such as a wrong byte lane or a write accepted from a foreign module select, stays invisible until the next read of that word. The bench therefore reads back every word it writes, including words it aimed foreign requests at.

// File: rtl/bus_mem_slave.sv
module bus_mem_slave #(
  parameter int ADDR_W = 18,
  parameter int SEL_W = 5,
  parameter logic [SEL_W-1:0] MODULE_ID = 5'd3,
  parameter int WORDS = 256,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic              ack,
  output logic [15:0]       rdata
);

  localparam int OFF_W = $clog2(WORDS);
  localparam int CNT_W = $clog2(LATENCY + 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_t;

  state_t           state;
  logic             req_q1, req_q2;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      mem [WORDS];

  wire             hit    = addr[ADDR_W-1 -: SEL_W] == MODULE_ID;
  wire [OFF_W-1:0] widx   = addr[OFF_W:1];
  wire             do_acc = (state == S_BUSY) && (cnt == CNT_W'(LATENCY - 1));

  always_ff @(posedge clk) begin
    if (do_acc && wr) begin
      if (!byte_mode || !addr[0]) mem[widx][7:0]  <= wdata[7:0];
      if (!byte_mode ||  addr[0]) mem[widx][15:8] <= wdata[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q1 <= 1'b0;
      req_q2 <= 1'b0;
      state  <= S_IDLE;
      cnt    <= '0;
      ack    <= 1'b0;
      rdata  <= '0;
    end else begin
      req_q1 <= req;
      req_q2 <= req_q1;
      case (state)
        S_IDLE: if (req_q2 && hit) begin
          state <= S_BUSY;
          cnt   <= '0;
        end
        S_BUSY: if (do_acc) begin
          state <= S_DONE;
          ack   <= 1'b1;
          if (!wr) rdata <= mem[widx];
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_DONE: if (!req_q2) begin
          state <= S_IDLE;
          ack   <= 1'b0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bus_mem_slave_chk.sv
module bus_mem_slave_chk #(
  parameter int ADDR_W = 18,
  parameter int SEL_W = 5,
  parameter logic [SEL_W-1:0] MODULE_ID = 5'd3,
  parameter int LATENCY = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [ADDR_W-1:0] addr,
  input logic              ack,
  input logic [15:0]       rdata
);

  logic [15:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else if (!req) wait_cnt <= '0;
    else if (!ack && wait_cnt != 16'hFFFF) wait_cnt <= wait_cnt + 16'd1;
  end

  a_r2_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> wait_cnt >= 16'(LATENCY));

  a_r3_hold_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack && req |=> ack);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req && !ack |=> !ack);

  a_r4_rdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ack && $past(ack) |-> $stable(rdata));

  a_r7_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack && (addr[ADDR_W-1 -: SEL_W] != MODULE_ID) |=> !ack);

endmodule

bind bus_mem_slave bus_mem_slave_chk #(
  .ADDR_W(ADDR_W), .SEL_W(SEL_W), .MODULE_ID(MODULE_ID), .LATENCY(LATENCY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .ack(ack), .rdata(rdata)
);

// File: tb/test_bus_mem_slave.sv
module test_bus_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;
  localparam logic [4:0] MID = 5'd3;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, wr = 1'b0, byte_mode = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ack;
  logic [15:0] rdata;

  int checks = 0, errors = 0, cycles = 0;

  bus_mem_slave #(.MODULE_ID(MID), .LATENCY(LAT)) i_bus_mem_slave (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .byte_mode(byte_mode),
    .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int          sync_q[$];
  logic [15:0] mem_m[int];
  int          phase = 0, wait_n = 0;
  logic        ack_e = 1'b0;
  logic [15:0] rdata_e = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q = '{0, 0};
      phase = 0; ack_e = 1'b0; rdata_e = '0;
    end else begin
      int seen;
      int w;
      sync_q.push_back(int'(req));
      seen = sync_q.pop_front();
      w = int'(addr[8:1]);
      if (phase == 0) begin
        if (seen != 0 && addr[17:13] == MID) begin phase = 1; wait_n = 1; end
      end else if (phase == 1) begin
        if (wait_n == LAT) begin
          logic [15:0] cur;
          cur = mem_m.exists(w) ? mem_m[w] : 16'h0000;
          if (wr) begin
            if (!byte_mode || !addr[0]) cur[7:0] = wdata[7:0];
            if (!byte_mode || addr[0]) cur[15:8] = wdata[15:8];
            mem_m[w] = cur;
          end else rdata_e = cur;
          ack_e = 1'b1; phase = 2;
        end else wait_n++;
      end else if (seen == 0) begin
        ack_e = 1'b0; phase = 0;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (ack !== ack_e) begin
        errors++;
        $display("FAIL R2/R3 model ack: actual %b expected %b at cycle %0d", ack, ack_e, cycles);
      end
      checks++;
      if (rdata !== rdata_e) begin
        errors++;
        $display("FAIL R4 model rdata: actual %h expected %h at cycle %0d", rdata, rdata_e, cycles);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic w, input logic b, input logic [17:0] a,
                      input logic [15:0] d, input int hold,
                      output logic [15:0] rd, output int lat, output int fall);
    @(negedge clk);
    wr = w; byte_mode = b; addr = a; wdata = d; req = 1'b1;
    lat = 0;
    while (lat < 200) begin
      @(negedge clk); lat++;
      if (ack) break;
    end
    rd = rdata;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R4 rdata held while ack high", rdata, rd);
    end
    req = 1'b0;
    fall = 0;
    while (fall < 200) begin
      @(negedge clk); fall++;
      if (!ack) break;
    end
    @(negedge clk);
  endtask

  function automatic logic [17:0] mk(input logic [4:0] m, input int word, input logic lane);
    return {m, 4'd0, 8'(word), lane};
  endfunction

  initial begin
    logic [15:0] rd;
    int lat, fall;
    repeat (3) @(negedge clk);
    check("R1 ack in reset", ack, 0);
    check("R1 rdata in reset", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ack after reset", ack, 0);
    check("R1 rdata after reset", rdata, 0);

    xfer(1, 0, mk(MID, 5, 0), 16'hA5C3, 0, rd, lat, fall);
    check("R2 write ack latency", lat, LAT + 3);
    check("R3 ack falls third edge", fall, 3);
    xfer(0, 0, mk(MID, 5, 0), 0, 6, rd, lat, fall);
    check("R5 word write readback", rd, 16'hA5C3);
    check("R2 read ack latency", lat, LAT + 3);
    check("R3 ack fall after hold", fall, 3);

    xfer(1, 0, mk(MID, 9, 0), 16'h1234, 0, rd, lat, fall);
    xfer(1, 1, mk(MID, 9, 0), 16'hFFEE, 0, rd, lat, fall);
    xfer(0, 0, mk(MID, 9, 0), 0, 0, rd, lat, fall);
    check("R6 low lane byte write", rd, 16'h12EE);
    xfer(1, 1, mk(MID, 9, 1), 16'h77FF, 0, rd, lat, fall);
    xfer(0, 0, mk(MID, 9, 0), 0, 0, rd, lat, fall);
    check("R6 high lane byte write", rd, 16'h77EE);

    @(negedge clk);
    wr = 1; byte_mode = 0; addr = mk(5'd4, 5, 0); wdata = 16'h0BAD; req = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (ack) begin
        errors++;
        $display("FAIL R7 foreign ack: actual 1 expected 0");
      end
    end
    checks++;
    req = 1'b0;
    repeat (4) @(negedge clk);
    xfer(0, 0, mk(MID, 5, 0), 0, 0, rd, lat, fall);
    check("R7 foreign write left word", rd, 16'hA5C3);

    for (int k = 0; k < 8; k++)
      xfer(1, 0, mk(MID, 100 + k, 0), 16'(k * 16'h1111 + 7), k % 3, rd, lat, fall);
    for (int k = 0; k < 8; k++) begin
      xfer(0, 0, mk(MID, 100 + k, 0), 0, k % 2, rd, lat, fall);
      check("R4 read pattern", rd, 16'(k * 16'h1111 + 7));
    end

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule